// File: doc/BRIEF.md
# Signed-Digit Quotient Converter with Rounding

This block sits at the output of a radix-16 digit-recurrence divider. Each iteration the recurrence produces one signed quotient digit in the range -10 to +10. The block folds each digit into a conventional binary quotient as the digit arrives, so no carry-propagate addition is needed once the last digit is in.

It keeps two candidate values side by side: the partial quotient Q and its predecessor Q-1. Each digit shifts one of the two candidates up by four bits, chosen by the digit's sign, and appends a new low nibble. This keeps Q-1 exact without any carry chain.

When the divider has finished, it raises a finish strobe together with the sign of the final residual and a flag saying whether that residual is zero. The block picks the truncated quotient from one of the two candidates and rounds it to the nearest value at the output width. The result appears one cycle later.

Top module: `odc_convert_round`

## Requirements
- R1: After reset, and in the cycle after `start`, the candidates hold Q = 0 and Q-1 = all ones. A finish with no digits in between, a non-negative residual and the zero flag set yields a quotient of 0.
- R2: On a valid digit d >= 0, Q becomes 16*Q + d. The quotient value is the digits weighted by powers of 16, most significant digit first, modulo 2^(4*DIGITS).
- R3: On a valid digit d < 0, Q becomes 16*(Q-1) + (16+d). This equals 16*Q + d, so negative digits need no carry propagation.
- R4: A cycle with neither `start` nor `dig_valid` leaves both candidates unchanged, whatever `digit`, `res_neg` or `res_zero` carry.
- R5: At finish, a negative residual (`res_neg`=1) selects Q-1 as the truncated quotient. Otherwise Q is selected.
- R6: The output keeps the top OUT_W bits of the 4*DIGITS-bit truncated value. The bit just below them is the guard bit. The sticky bit is the OR of all lower bits and the inverse of `res_zero`.
- R7: Rounding is to nearest. With guard set and sticky clear (an exact tie), the result rounds to an even kept value.
- R8: `quot_valid` is high exactly in the cycle after `fin`. `quotient` changes only in that cycle and holds otherwise. A finish uses the candidates as they stood before any digit accepted in the same cycle.
- R9: `start` takes priority over `dig_valid` in the same cycle. The digit is discarded.
- R10: `digit` is a 5-bit two's-complement value. While `dig_valid` is high it must lie in [-10, 10].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the candidates for a new division |
| dig_valid | input | 1 | `digit` carries a quotient digit this cycle |
| digit | input | 5 | Signed quotient digit, two's complement |
| fin | input | 1 | Finish strobe: round and present the quotient |
| res_neg | input | 1 | Final residual is negative (sampled with `fin`) |
| res_zero | input | 1 | Final residual is zero (sampled with `fin`) |
| quotient | output | 53 | Rounded quotient |
| quot_valid | output | 1 | `quotient` was updated in this cycle |

## Verification
The embedded properties check several things on every cycle. Q stays exactly one above Q-1. Both candidates clear after `start`, even when a digit arrives alongside it. Idle cycles leave the candidates untouched. `quot_valid` tracks `fin` with one cycle of delay. `quotient` holds between finishes. Digits stay in range.

Some behaviour can only be shown by the bench's scenarios, which compare against an arithmetic model of the digit sum. These include the numeric value built from mixed-sign digits and the choice of Q-1 on a negative residual. They also include the guard and sticky decision and the tie-to-even cases. Sticky is driven only by the zero flag in some of these cases.

// File: rtl/odc_pkg.sv
package odc_pkg;
   // Tie-breaking variant of the round-to-nearest step.
   typedef enum logic {
      TIE_EVEN = 1'b0,
      TIE_AWAY = 1'b1
   } odc_tie_e;
endpackage

// File: rtl/odc_cand_regs.sv
// Twin candidate registers: Q and Q-1, updated by shift-and-append.
module odc_cand_regs #(
   parameter int RADIX_LOG = 4,
   parameter int DIGITS    = 14,
   parameter int MAX_DIGIT = 10,
   localparam int ACC_W    = RADIX_LOG * DIGITS,
   localparam int DIG_W    = RADIX_LOG + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             dig_valid,
   input  logic [DIG_W-1:0] digit,
   output logic [ACC_W-1:0] q_r,
   output logic [ACC_W-1:0] qm_r
);
   logic                 neg;
   logic                 pos;
   logic [DIG_W-1:0]     digit_m1;
   logic [RADIX_LOG-1:0] q_nib;
   logic [RADIX_LOG-1:0] qm_nib;
   logic [ACC_W-1:0]     q_src;
   logic [ACC_W-1:0]     qm_src;

   // Low nibbles are the digit and digit-1 taken modulo the radix, for
   // either sign; only the register being shifted depends on the sign.
   always_comb begin
      neg      = digit[DIG_W-1];
      pos      = !neg && (digit != '0);
      digit_m1 = digit - DIG_W'(1);
      q_nib    = digit[RADIX_LOG-1:0];
      qm_nib   = digit_m1[RADIX_LOG-1:0];
      q_src    = neg ? qm_r : q_r;
      qm_src   = pos ? q_r  : qm_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r  <= '0;
         qm_r <= '1;
      end else if (start) begin
         q_r  <= '0;
         qm_r <= '1;
      end else if (dig_valid) begin
         q_r  <= {q_src[ACC_W-RADIX_LOG-1:0], q_nib};
         qm_r <= {qm_src[ACC_W-RADIX_LOG-1:0], qm_nib};
      end
   end

   // R2 / R3: the predecessor stays exactly one below Q.
   a_r2_r3_pair_offset : assert property (@(posedge clk) disable iff (!rst_n)
      q_r == qm_r + ACC_W'(1));

   // R1 / R9: start clears, regardless of a digit in the same cycle.
   a_r1_r9_start_clears : assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (q_r == '0) && (qm_r == '1));

   // R4: idle cycles leave both candidates unchanged.
   a_r4_idle_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !dig_valid) |=> ($stable(q_r) && $stable(qm_r)));

   // R10: digits stay inside the digit set.
   a_r10_digit_range : assert property (@(posedge clk) disable iff (!rst_n)
      dig_valid |-> (($signed(digit) <= MAX_DIGIT) && ($signed(digit) >= -MAX_DIGIT)));
endmodule

// File: rtl/odc_round.sv
// Round-to-nearest of the truncated quotient down to OUT_W bits.
module odc_round
   import odc_pkg::*;
#(
   parameter int       ACC_W = 56,
   parameter int       OUT_W = 53,
   parameter odc_tie_e TIE   = TIE_EVEN,
   localparam int      LOW_W = ACC_W - OUT_W
) (
   input  logic [ACC_W-1:0] trunc,
   input  logic             exact,
   output logic [OUT_W-1:0] rounded
);
   logic [OUT_W-1:0] kept;
   logic             guard;
   logic             sticky;
   logic             inc;

   assign kept  = trunc[ACC_W-1:LOW_W];
   assign guard = trunc[LOW_W-1];

   generate
      if (LOW_W >= 2) begin : g_sticky_bits
         assign sticky = (|trunc[LOW_W-2:0]) | ~exact;
      end else begin : g_sticky_flag
         assign sticky = ~exact;
      end

      if (TIE == TIE_EVEN) begin : g_tie_even
         assign inc = guard & (sticky | kept[0]);
      end else begin : g_tie_away
         assign inc = guard;
      end
   endgenerate

   assign rounded = kept + OUT_W'(inc);
endmodule

// File: rtl/odc_convert_round.sv
// On-the-fly signed-digit quotient converter with final rounding.
module odc_convert_round
   import odc_pkg::*;
#(
   parameter int       RADIX_LOG = 4,
   parameter int       DIGITS    = 14,
   parameter int       OUT_W     = 53,
   parameter int       MAX_DIGIT = 10,
   parameter odc_tie_e TIE       = TIE_EVEN,
   localparam int      ACC_W     = RADIX_LOG * DIGITS,
   localparam int      DIG_W     = RADIX_LOG + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             dig_valid,
   input  logic [DIG_W-1:0] digit,
   input  logic             fin,
   input  logic             res_neg,
   input  logic             res_zero,
   output logic [OUT_W-1:0] quotient,
   output logic             quot_valid
);
   generate
      if (ACC_W <= OUT_W) begin : g_bad_width
         $error("odc_convert_round: digits must supply at least one bit below OUT_W");
      end
      if (MAX_DIGIT >= (1 << RADIX_LOG)) begin : g_bad_digit
         $error("odc_convert_round: MAX_DIGIT must be below the radix");
      end
   endgenerate

   logic [ACC_W-1:0] q_r;
   logic [ACC_W-1:0] qm_r;
   logic [ACC_W-1:0] trunc;
   logic [OUT_W-1:0] rounded;

   odc_cand_regs #(
      .RADIX_LOG (RADIX_LOG),
      .DIGITS    (DIGITS),
      .MAX_DIGIT (MAX_DIGIT)
   ) u_cand (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .dig_valid (dig_valid),
      .digit     (digit),
      .q_r       (q_r),
      .qm_r      (qm_r)
   );

   // R5: a negative residual means Q overshot by one unit.
   assign trunc = res_neg ? qm_r : q_r;

   odc_round #(
      .ACC_W (ACC_W),
      .OUT_W (OUT_W),
      .TIE   (TIE)
   ) u_round (
      .trunc   (trunc),
      .exact   (res_zero),
      .rounded (rounded)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quotient   <= '0;
         quot_valid <= 1'b0;
      end else begin
         quot_valid <= fin;
         if (fin) quotient <= rounded;
      end
   end

   // R8: valid follows the finish strobe by one cycle.
   a_r8_valid_follows_fin : assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> quot_valid);
   a_r8_valid_needs_fin : assert property (@(posedge clk) disable iff (!rst_n)
      !fin |=> !quot_valid);
   // R8: result holds between finishes.
   a_r8_result_holds : assert property (@(posedge clk) disable iff (!rst_n)
      !fin |=> $stable(quotient));
endmodule

// File: tb/odc_convert_round_test.sv
module odc_convert_round_test;
   localparam int ACC_W = 56;
   localparam int OUT_W = 53;
   localparam logic [63:0] MASK  = (64'd1 << ACC_W) - 64'd1;
   localparam logic [63:0] OMASK = (64'd1 << OUT_W) - 64'd1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic             dig_valid = 1'b0;
   logic [4:0]       digit = '0;
   logic             fin = 1'b0;
   logic             res_neg = 1'b0;
   logic             res_zero = 1'b0;
   logic [OUT_W-1:0] quotient;
   logic             quot_valid;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   // Reference model state
   logic [63:0]      mv = '0;
   logic [OUT_W-1:0] e_q = '0;
   logic             e_valid = 1'b0;
   int unsigned      seed = 32'd12345;

   always #5 clk = ~clk;

   odc_convert_round uut (
      .clk(clk), .rst_n(rst_n), .start(start), .dig_valid(dig_valid),
      .digit(digit), .fin(fin), .res_neg(res_neg), .res_zero(res_zero),
      .quotient(quotient), .quot_valid(quot_valid)
   );

   // Rounding from the requirements: select (R5), guard/sticky (R6), tie even (R7)
   function automatic logic [OUT_W-1:0] rnd(logic [63:0] v, bit neg, bit zero);
      logic [63:0] t;
      logic [63:0] hi;
      bit g, s, inc;
      t   = neg ? ((v - 64'd1) & MASK) : v;
      hi  = t >> (ACC_W - OUT_W);
      g   = t[ACC_W-OUT_W-1];
      s   = (t[ACC_W-OUT_W-2:0] != '0) || !zero;
      inc = g && (s || hi[0]);
      return OUT_W'((hi + 64'(inc)) & OMASK);
   endfunction

   task automatic tick(bit st, bit dv, int d, bit fn, bit ng, bit zr, string req);
      start = st; dig_valid = dv; digit = 5'(d); fin = fn; res_neg = ng; res_zero = zr;
      @(posedge clk);
      e_valid = fn;
      if (fn) e_q = rnd(mv, ng, zr);
      if (st) mv = '0;
      else if (dv) mv = ((mv << 4) + 64'(longint'(d))) & MASK;
      @(negedge clk);
      compared++;
      if (quot_valid !== e_valid || quotient !== e_q) begin
         mismatched++;
         $display("FAIL %s: valid=%0b quotient=%h expected valid=%0b quotient=%h",
                  req, quot_valid, quotient, e_valid, e_q);
      end
   endtask

   task automatic idle(string req);
      tick(1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, req);
   endtask

   task automatic next_rand(output int d);
      seed = seed * 32'd1103515245 + 32'd12345;
      d = int'((seed >> 16) % 21) - 10;
   endtask

   initial begin
      int d;
      // Reset state (R1)
      repeat (3) @(negedge clk);
      compared++;
      if (quotient !== '0 || quot_valid !== 1'b0) begin
         mismatched++;
         $display("FAIL R1: reset valid=%0b quotient=%h expected 0/0", quot_valid, quotient);
      end
      rst_n = 1'b1;
      idle("R1");
      // R1: finish with no digits gives 0
      tick(1'b0, 1'b0, 0, 1'b1, 1'b0, 1'b1, "R1");
      idle("R8");

      // R2: non-negative digits, inexact positive residual (R6 sticky)
      tick(1'b1, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R1");
      foreach (d_list_a[i]) tick(1'b0, 1'b1, d_list_a[i], 1'b0, 1'b0, 1'b0, "R2");
      tick(1'b0, 1'b0, 0, 1'b1, 1'b0, 1'b0, "R2");
      idle("R8");
      tick(1'b0, 1'b0, 0, 1'b1, 1'b1, 1'b0, "R5");

      // R3: mixed signs, negative residual selects Q-1 (R5)
      tick(1'b1, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R1");
      foreach (d_list_b[i]) tick(1'b0, 1'b1, d_list_b[i], 1'b0, 1'b0, 1'b0, "R3");
      tick(1'b0, 1'b0, 0, 1'b1, 1'b1, 1'b0, "R5");
      tick(1'b0, 1'b0, 0, 1'b1, 1'b0, 1'b1, "R3");

      // R7: exact tie, kept LSB even -> stays; R6: zero flag clear -> rounds up
      tick(1'b1, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R1");
      tick(1'b0, 1'b1, 8, 1'b0, 1'b0, 1'b0, "R7");
      repeat (12) tick(1'b0, 1'b1, 0, 1'b0, 1'b0, 1'b0, "R7");
      tick(1'b0, 1'b1, 4, 1'b0, 1'b0, 1'b0, "R7");
      tick(1'b0, 1'b0, 0, 1'b1, 1'b0, 1'b1, "R7");
      tick(1'b0, 1'b0, 0, 1'b1, 1'b0, 1'b0, "R6");
      // R7: tie with odd kept LSB (last digit -4) -> rounds up
      tick(1'b1, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R1");
      tick(1'b0, 1'b1, 9, 1'b0, 1'b0, 1'b0, "R7");
      repeat (12) tick(1'b0, 1'b1, 3, 1'b0, 1'b0, 1'b0, "R7");
      tick(1'b0, 1'b1, -4, 1'b0, 1'b0, 1'b0, "R7");
      tick(1'b0, 1'b0, 0, 1'b1, 1'b0, 1'b1, "R7");

      // R4: idle cycles with noise on digit and residual flags are ignored
      tick(1'b1, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R1");
      for (int i = 0; i < 14; i++) begin
         next_rand(d);
         tick(1'b0, 1'b1, d, 1'b0, 1'b0, 1'b0, "R4");
         tick(1'b0, 1'b0, -d, 1'b0, 1'b1, 1'b1, "R4");
      end
      tick(1'b0, 1'b0, 0, 1'b1, 1'b0, 1'b0, "R4");

      // R9: start with a digit in the same cycle discards the digit
      tick(1'b0, 1'b1, 7, 1'b0, 1'b0, 1'b0, "R9");
      tick(1'b1, 1'b1, 9, 1'b0, 1'b0, 1'b0, "R9");
      tick(1'b0, 1'b0, 0, 1'b1, 1'b0, 1'b1, "R9");

      // R8: finish in the same cycle as a digit uses pre-digit value
      tick(1'b0, 1'b1, 5, 1'b0, 1'b0, 1'b0, "R8");
      tick(1'b0, 1'b1, -6, 1'b1, 1'b0, 1'b0, "R8");
      tick(1'b0, 1'b0, 0, 1'b1, 1'b0, 1'b0, "R8");

      // Random full divisions (R2, R3, R5, R6)
      for (int run = 0; run < 30; run++) begin
         tick(1'b1, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R1");
         for (int i = 0; i < 14; i++) begin
            next_rand(d);
            if (i == 0 && d <= 0) d = 8;
            tick(1'b0, 1'b1, d, 1'b0, 1'b0, 1'b0, "R3");
         end
         tick(1'b0, 1'b0, 0, 1'b1, seed[20], seed[21] & seed[22], "R6");
         idle("R8");
      end

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   int d_list_a[14] = '{8, 3, 0, 10, 1, 0, 7, 2, 9, 0, 5, 6, 4, 1};
   int d_list_b[14] = '{9, -3, 0, -10, 4, -1, 10, -7, 2, 0, -5, 6, -8, 3};

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         mismatched++;
         compared++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule